// File: doc/BRIEF.md
# Bridge Configuration and I/O Cycle Generator

This block sits on the direct-master path of a local-bus-to-PCI bridge. It takes one local request at a time and produces the address phase of a single PCI cycle: the 32-bit address, the 4-bit command and the byte enables. Bit 31 of the configuration address register picks the cycle kind. When that bit is clear, the access becomes an I/O read or write. When it is set, the access becomes a configuration read or write, either Type 0 or Type 1.

For an I/O cycle, the upper address comes from a remap window. A mask input chooses, bit by bit, whether an address bit comes from the remap value or from the local address. Address bits [1:0] carry the position of the lowest enabled byte. For a Type 0 configuration cycle, the device number is turned into a single select bit in the upper address. For a Type 1 cycle, the top byte of the address is cleared.

Writes are posted. The data goes into an external write FIFO and the local side gets its ready at once, unless the FIFO reports full. Reads keep the local ready low until one 32-bit word comes back on the completion interface.

Top module: `pci_cfgio_cycle_gen`

## Requirements
- R1: After reset, `lcl_rdy`, `pci_start`, `wf_push` and `cfg_err` are all low.
- R2: With `cfg_addr_reg[31]`=0, the cycle uses command 4'h2 for a read and 4'h3 for a write. Its address bits [31:2] equal `((lcl_addr & ~io_mask) | (io_remap & io_mask))[31:2]`. Its bits [1:0] are the index (0..3) of the lowest set bit of `lcl_be`, or 0 when no byte is enabled.
- R3: With `cfg_addr_reg[31]`=1, the cycle uses command 4'hA for a read and 4'hB for a write.
- R4: In a configuration cycle with `cfg_addr_reg[0]`=0 (Type 0) and device number `cfg_addr_reg[15:11]` ≤ 20, the address is built as follows. Bits [10:2] are copied from the register, bits [1:0] are 00, and bits [31:11] hold exactly one set bit, at position 11 + device number.
- R5: In a Type 0 cycle with a device number above 20, address bits [31:11] are all zero and `cfg_err` is high in the same cycle as `pci_start`. In every other cycle `cfg_err` is low.
- R6: In a configuration cycle with `cfg_addr_reg[0]`=1 (Type 1), the address is built as follows. Bits [31:24] are zero, bits [23:2] are copied from the register, and bits [1:0] are 01.
- R7: The cycle after an accepted write, `pci_start`, `wf_push` and `lcl_rdy` are high together for exactly one cycle, and `wf_data` equals the local write data.
- R8: While `wf_full` is high, a pending write is neither pushed nor acknowledged. It is accepted on the first edge at which `wf_full` is low.
- R9: A read produces a one-cycle `pci_start` while `lcl_rdy` stays low. `lcl_rdy` goes high for one cycle only in the cycle after `pci_rd_vld`, and `lcl_rdata` then carries `pci_rd_data`.
- R10: `pci_be` equals `lcl_be` whenever `pci_start` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lcl_req | input | 1 | Local request, held until `lcl_rdy` |
| lcl_wr | input | 1 | 1 = write, 0 = read |
| lcl_addr | input | 32 | Local address |
| lcl_be | input | 4 | Local byte enables, active high |
| lcl_wdata | input | 32 | Local write data |
| cfg_addr_reg | input | 32 | Configuration address register |
| io_remap | input | 32 | Remap value for I/O address bits |
| io_mask | input | 32 | 1 = take the bit from `io_remap` |
| lcl_rdy | output | 1 | Local ready, one-cycle pulse |
| lcl_rdata | output | 32 | Read data returned to the local side |
| pci_start | output | 1 | Address phase valid, one-cycle pulse |
| pci_addr | output | 32 | Address for the address phase |
| pci_cmd | output | 4 | Command code |
| pci_be | output | 4 | Byte enables for the cycle |
| cfg_err | output | 1 | Type 0 device number has no select line |
| pci_rd_vld | input | 1 | Read completion word valid |
| pci_rd_data | input | 32 | Read completion word |
| wf_full | input | 1 | Write FIFO full |
| wf_push | output | 1 | Write FIFO push |
| wf_data | output | 32 | Write FIFO data |

## Verification
The assertions check several rules on every cycle. Every issued command is one of the four legal codes. A Type 0 select field is either one-hot or, on error, zero. No push happens while the FIFO is full. The ready is always a single-cycle pulse, and a read completion is always followed by ready with the returned word. The exact address values depend on the register contents, so only the bench sweeps can show them. Those sweeps cover every device number, every byte-enable pattern, several Type 1 register values, and the stall and release timing against the FIFO flag and the completion input.

// File: rtl/pci_cfgio_cycle_gen.sv
module pci_cfgio_cycle_gen #(
  parameter int SEL_LSB = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lcl_req,
  input  logic        lcl_wr,
  input  logic [31:0] lcl_addr,
  input  logic [3:0]  lcl_be,
  input  logic [31:0] lcl_wdata,
  input  logic [31:0] cfg_addr_reg,
  input  logic [31:0] io_remap,
  input  logic [31:0] io_mask,
  output logic        lcl_rdy,
  output logic [31:0] lcl_rdata,
  output logic        pci_start,
  output logic [31:0] pci_addr,
  output logic [3:0]  pci_cmd,
  output logic [3:0]  pci_be,
  output logic        cfg_err,
  input  logic        pci_rd_vld,
  input  logic [31:0] pci_rd_data,
  input  logic        wf_full,
  output logic        wf_push,
  output logic [31:0] wf_data
);
  localparam int NUM_SEL = 32 - SEL_LSB;
  localparam logic [3:0] CMD_IO_RD  = 4'h2;
  localparam logic [3:0] CMD_IO_WR  = 4'h3;
  localparam logic [3:0] CMD_CFG_RD = 4'hA;
  localparam logic [3:0] CMD_CFG_WR = 4'hB;

  logic rd_wait;
  logic accept;
  logic cfg_mode, type1;
  logic [4:0] dev_num;
  logic dev_bad;
  logic [NUM_SEL-1:0] sel_field;
  logic [1:0] be_pos;
  logic [31:0] io_addr, cfg_addr, next_addr;
  logic [3:0] next_cmd;

  assign cfg_mode = cfg_addr_reg[31];
  assign type1    = cfg_addr_reg[0];
  assign dev_num  = cfg_addr_reg[15:11];
  assign dev_bad  = cfg_mode && !type1 && (int'(dev_num) >= NUM_SEL);

  assign accept = lcl_req && !rd_wait && !lcl_rdy && !(lcl_wr && wf_full);

  always_comb begin
    sel_field = '0;
    if (int'(dev_num) < NUM_SEL) sel_field[dev_num] = 1'b1;
  end

  assign be_pos = lcl_be[0] ? 2'd0 :
                  lcl_be[1] ? 2'd1 :
                  lcl_be[2] ? 2'd2 :
                  lcl_be[3] ? 2'd3 : 2'd0;

  assign io_addr  = {((lcl_addr[31:2] & ~io_mask[31:2]) | (io_remap[31:2] & io_mask[31:2])), be_pos};
  assign cfg_addr = type1 ? {8'h00, cfg_addr_reg[23:2], 2'b01}
                          : {sel_field, cfg_addr_reg[SEL_LSB-1:2], 2'b00};
  assign next_addr = cfg_mode ? cfg_addr : io_addr;
  assign next_cmd  = cfg_mode ? (lcl_wr ? CMD_CFG_WR : CMD_CFG_RD)
                              : (lcl_wr ? CMD_IO_WR  : CMD_IO_RD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_wait   <= 1'b0;
      lcl_rdy   <= 1'b0;
      lcl_rdata <= '0;
      pci_start <= 1'b0;
      pci_addr  <= '0;
      pci_cmd   <= '0;
      pci_be    <= '0;
      cfg_err   <= 1'b0;
      wf_push   <= 1'b0;
      wf_data   <= '0;
    end else begin
      pci_start <= accept;
      cfg_err   <= accept && dev_bad;
      wf_push   <= accept && lcl_wr;
      lcl_rdy   <= (accept && lcl_wr) || (rd_wait && pci_rd_vld);
      if (accept) begin
        pci_addr <= next_addr;
        pci_cmd  <= next_cmd;
        pci_be   <= lcl_be;
        if (lcl_wr) wf_data <= lcl_wdata;
        else        rd_wait <= 1'b1;
      end else if (rd_wait && pci_rd_vld) begin
        rd_wait   <= 1'b0;
        lcl_rdata <= pci_rd_data;
      end
    end
  end

  p_cmd_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pci_start |-> (pci_cmd == CMD_IO_RD || pci_cmd == CMD_IO_WR ||
                   pci_cmd == CMD_CFG_RD || pci_cmd == CMD_CFG_WR));

  p_sel_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_start && pci_cmd[3] && pci_addr[1:0] == 2'b00 && !cfg_err)
      |-> $countones(pci_addr[31:SEL_LSB]) == 1);

  p_err_sel_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (pci_start && pci_addr[31:SEL_LSB] == '0));

  p_no_push_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wf_push |-> !$past(wf_full));

  p_rdy_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lcl_rdy |=> !lcl_rdy);

  p_rd_return_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_wait && pci_rd_vld) |=> (lcl_rdy && lcl_rdata == $past(pci_rd_data)));
endmodule

// File: tb/pci_cfgio_cycle_gen_tb.sv
`timescale 1ns/1ps
module pci_cfgio_cycle_gen_tb;
  logic clk = 0, rst_n = 0;
  logic lcl_req = 0, lcl_wr = 0;
  logic [31:0] lcl_addr = 0, lcl_wdata = 0, cfg_addr_reg = 0;
  logic [31:0] io_remap = 32'h00AB_0000, io_mask = 32'hFFFF_0000;
  logic [3:0]  lcl_be = 0;
  logic lcl_rdy, pci_start, cfg_err, wf_push;
  logic [31:0] lcl_rdata, pci_addr, wf_data;
  logic [3:0] pci_cmd, pci_be;
  logic pci_rd_vld = 0, wf_full = 0;
  logic [31:0] pci_rd_data = 0;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pci_cfgio_cycle_gen u_dut (
    .clk, .rst_n, .lcl_req, .lcl_wr, .lcl_addr, .lcl_be, .lcl_wdata,
    .cfg_addr_reg, .io_remap, .io_mask, .lcl_rdy, .lcl_rdata, .pci_start,
    .pci_addr, .pci_cmd, .pci_be, .cfg_err, .pci_rd_vld, .pci_rd_data,
    .wf_full, .wf_push, .wf_data);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [31:0] la, input logic [3:0] be, input logic [31:0] cr);
    logic [31:0] a;
    int dev;
    if (!cr[31]) begin
      a = ((la & ~io_mask) | (io_remap & io_mask)) & 32'hFFFF_FFFC;
      for (int i = 3; i >= 0; i--) if (be[i]) a[1:0] = 2'(i);
    end else if (cr[0]) begin
      a = (cr & 32'h00FF_FFFC) | 32'h1;
    end else begin
      dev = int'(cr[15:11]);
      a = cr & 32'h0000_07FC;
      if (dev <= 20) a = a + (32'h800 << dev);
    end
    return a;
  endfunction

  task automatic access(input bit wr, input logic [31:0] la, input logic [3:0] be,
                        input logic [31:0] cr, input logic [31:0] data, input string tag);
    logic [31:0] ea;
    logic [3:0] ec;
    bit eerr;
    ea = exp_addr(la, be, cr);
    ec = cr[31] ? (wr ? 4'hB : 4'hA) : (wr ? 4'h3 : 4'h2);
    eerr = cr[31] && !cr[0] && (cr[15:11] > 20);
    lcl_wr = wr; lcl_addr = la; lcl_be = be; cfg_addr_reg = cr; lcl_wdata = data;
    lcl_req = 1;
    @(posedge clk); @(negedge clk);
    chk(pci_start == 1, {tag, " start"}, 32'(pci_start), 1);
    chk(pci_addr == ea, {tag, " addr"}, pci_addr, ea);
    chk(pci_cmd == ec, {tag, " cmd"}, 32'(pci_cmd), 32'(ec));
    chk(pci_be == be, "R10 be", 32'(pci_be), 32'(be));
    chk(cfg_err == eerr, "R5 err", 32'(cfg_err), 32'(eerr));
    if (wr) begin
      chk(wf_push && lcl_rdy && wf_data == data, "R7 write ack", wf_data, data);
      lcl_req = 0;
      @(posedge clk); @(negedge clk);
      chk(!lcl_rdy && !wf_push && !pci_start, "R7 single pulse", 32'({lcl_rdy, wf_push, pci_start}), 0);
    end else begin
      chk(!lcl_rdy && !wf_push, "R9 rdy held", 32'(lcl_rdy), 0);
      @(posedge clk); @(negedge clk);
      chk(!lcl_rdy && !pci_start, "R9 waiting", 32'({lcl_rdy, pci_start}), 0);
      pci_rd_vld = 1; pci_rd_data = data;
      @(posedge clk); @(negedge clk);
      pci_rd_vld = 0; lcl_req = 0;
      chk(lcl_rdy && lcl_rdata == data, "R9 read return", lcl_rdata, data);
      @(posedge clk); @(negedge clk);
      chk(!lcl_rdy && !pci_start, "R9 single pulse", 32'({lcl_rdy, pci_start}), 0);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!lcl_rdy && !pci_start && !wf_push && !cfg_err, "R1 reset", 32'({lcl_rdy, pci_start, wf_push, cfg_err}), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!lcl_rdy && !pci_start && !wf_push && !cfg_err, "R1 idle", 32'({lcl_rdy, pci_start, wf_push, cfg_err}), 0);

    for (int b = 0; b < 16; b++) begin
      access(b[0], 32'h1234_5670 + 32'(b * 4), 4'(b), 32'h0, 32'hA500_0000 + 32'(b), "R2 io");
    end
    for (int d = 0; d < 32; d++) begin
      access(d[0], 32'h0, 4'hF, 32'h8000_0000 | (32'(d) << 11) | 32'h0000_0534, 32'hC0DE_0000 + 32'(d), "R4 type0");
    end
    access(0, 32'h0, 4'h3, 32'hFFFF_FFFD, 32'h1111_2222, "R6 type1");
    access(1, 32'h0, 4'hC, 32'h8055_AA11, 32'h3333_4444, "R6 type1");
    access(0, 32'h0, 4'h1, 32'h80FF_0005, 32'h5555_6666, "R3 type1 rd");

    wf_full = 1;
    lcl_wr = 1; lcl_addr = 32'h0000_0100; lcl_be = 4'hF; cfg_addr_reg = 0; lcl_wdata = 32'hFEED_BEEF;
    lcl_req = 1;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); @(negedge clk);
      chk(!lcl_rdy && !wf_push && !pci_start, "R8 stall", 32'({lcl_rdy, wf_push, pci_start}), 0);
    end
    wf_full = 0;
    @(posedge clk); @(negedge clk);
    chk(lcl_rdy && wf_push && wf_data == 32'hFEED_BEEF, "R8 release", wf_data, 32'hFEED_BEEF);
    lcl_req = 0;
    @(posedge clk); @(negedge clk);
    chk(!lcl_rdy && !wf_push, "R8 done", 32'({lcl_rdy, wf_push}), 0);

    pci_rd_vld = 1; pci_rd_data = 32'hDEAD_0000;
    @(posedge clk); @(negedge clk);
    pci_rd_vld = 0;
    chk(!lcl_rdy, "R9 stray completion", 32'(lcl_rdy), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule